// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time

This block turns two direction inputs and an enable into the four gate commands of one H-bridge. An H-bridge has two legs, and each leg has a high-side and a low-side switch. Each leg follows its own input. A logic 1 on an input turns on the high side of that leg, so the output goes to the supply rail. A logic 0 turns on the low side, so the output goes to ground. When both inputs are 1, both outputs sit at the supply rail.

Pulling the enable low turns every switch off and leaves both outputs floating. An active-low fault input from the protection logic does the same. The enable and the two direction inputs are asynchronous, so each passes through a two-flop synchronizer first. The fault input is assumed to come from the same clock domain and acts on the next edge.

Whenever a leg hands conduction from one switch to the other, the block holds both switches of that leg off for a programmable number of clock cycles (`DEAD_CYC`). It inserts the same wait when a leg leaves the floating state. A leg whose request does not change keeps its gates untouched. Two instances serve two independent bridges.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: For the first cycle after synchronous reset, and until the first dead-time wait completes, all four gates are off and `leg_hiz_o` is 2'b11.
- R2: While the synchronized enable is low, all gates are off and both `leg_hiz_o` bits are 1, whatever `in1_i` and `in2_i` are.
- R3: When `fault_n_i` is low at a clock edge, all gates are off and `leg_hiz_o` is 2'b11 after that edge.
- R4: When enabled and with no fault, leg 0 follows `in1_i` and leg 1 follows `in2_i`. For each leg, an input of 1 turns on the high side (`gate_hi_o[k]`=1, `gate_lo_o[k]`=0) and an input of 0 turns on the low side (`gate_hi_o[k]`=0, `gate_lo_o[k]`=1). All four input combinations follow this rule, including both inputs at 1.
- R5: The high-side and low-side gates of one leg are never on in the same cycle.
- R6: When a leg hands over from one switch to the other, both gates of that leg stay off for exactly `DEAD_CYC` cycles, and never fewer.
- R7: When a leg leaves the floating state (enable rising or fault clearing), it waits the full `DEAD_CYC` cycles before turning on any switch. With the enable rising, the gate turns on at the (`DEAD_CYC`+3)th clock edge after the input change.
- R8: A leg whose request does not change keeps its gates steady while the other leg switches.
- R9: A change on `in1_i`, `in2_i` or `en_i` has no effect at the outputs before the third clock edge after it. The old gate turns off exactly at that third edge.
- R10: `leg_hiz_o[k]` is 1 exactly when both gates of leg k are off, which includes the dead-time interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Bridge enable, asynchronous; low turns all switches off |
| in1_i | input | 1 | Direction input of leg 0, asynchronous |
| in2_i | input | 1 | Direction input of leg 1, asynchronous |
| fault_n_i | input | 1 | Fault from the protection logic, active low, synchronous |
| gate_hi_o | output | 2 | High-side gate command, one bit per leg |
| gate_lo_o | output | 2 | Low-side gate command, one bit per leg |
| leg_hiz_o | output | 2 | Leg output is floating (both switches off), one bit per leg |

## Verification
Four properties are checked on every cycle: no leg ever has both gates on, a gate only rises after at least `DEAD_CYC` cycles with both gates off, a gate only turns on when the request asked for that switch, and a fault or a disabled request turns everything off on the next edge. The bench scenarios cover what those per-cycle checks cannot show. They confirm the exact truth-table result for each input pattern and the precise edge counts through the synchronizer and the dead-time wait. They also confirm that the leg with an unchanged request keeps its gate without interruption.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // What the decode logic asks of one leg
  typedef enum logic [1:0] {
    REQ_OFF  = 2'd0,
    REQ_LOW  = 2'd1,
    REQ_HIGH = 2'd2
  } leg_req_t;

  // Per-leg sequencer state
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } leg_st_t;

  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= async_i;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  logic                    en_s,
  input  logic                    fault_n,
  input  logic [NUM_LEGS-1:0]     dir_s,
  output leg_req_t [NUM_LEGS-1:0] req_o
);
  always_comb begin
    for (int k = 0; k < NUM_LEGS; k++) begin
      if (!en_s || !fault_n) req_o[k] = REQ_OFF;
      else if (dir_s[k])     req_o[k] = REQ_HIGH;
      else                   req_o[k] = REQ_LOW;
    end
  end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 50
) (
  input  logic     clk,
  input  logic     rst,
  input  leg_req_t req_i,
  output logic     gate_hi_o,
  output logic     gate_lo_o,
  output logic     hiz_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);

  leg_st_t  st;
  leg_req_t cond;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OFF; cond <= REQ_OFF; cnt <= '0;
      gate_hi_o <= 1'b0; gate_lo_o <= 1'b0; hiz_o <= 1'b1;
    end else if (req_i == REQ_OFF) begin
      st <= ST_OFF; cond <= REQ_OFF; cnt <= '0;
      gate_hi_o <= 1'b0; gate_lo_o <= 1'b0; hiz_o <= 1'b1;
    end else begin
      case (st)
        ST_OFF: begin
          st  <= ST_WAIT;
          cnt <= CW'(DEAD_CYC - 1);
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            st        <= ST_ON;
            cond      <= req_i;
            gate_hi_o <= (req_i == REQ_HIGH);
            gate_lo_o <= (req_i == REQ_LOW);
            hiz_o     <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ON: begin
          if (req_i != cond) begin
            st        <= ST_WAIT;
            cnt       <= CW'(DEAD_CYC - 1);
            gate_hi_o <= 1'b0;
            gate_lo_o <= 1'b0;
            hiz_o     <= 1'b1;
          end
        end
        default: begin
          st <= ST_OFF;
          gate_hi_o <= 1'b0; gate_lo_o <= 1'b0; hiz_o <= 1'b1;
        end
      endcase
    end
  end

  // Checker state: consecutive cycles with both gates off (saturating)
  logic [CW-1:0] off_run;
  always_ff @(posedge clk) begin
    if (rst) off_run <= '0;
    else if (gate_hi_o || gate_lo_o) off_run <= '0;
    else if (off_run < CW'(DEAD_CYC)) off_run <= off_run + 1'b1;
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi_o && gate_lo_o));

  assert_dead_gap_hi_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi_o) |-> off_run >= CW'(DEAD_CYC));

  assert_dead_gap_lo_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo_o) |-> off_run >= CW'(DEAD_CYC));

  assert_hi_matches_req_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi_o) |-> $past(req_i) == REQ_HIGH);

  assert_lo_matches_req_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo_o) |-> $past(req_i) == REQ_LOW);

  assert_off_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_i == REQ_OFF |=> (hiz_o && !gate_hi_o && !gate_lo_o));
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC    = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       in1_i,
  input  logic       in2_i,
  input  logic       fault_n_i,
  output logic [1:0] gate_hi_o,
  output logic [1:0] gate_lo_o,
  output logic [1:0] leg_hiz_o
);
  localparam int unsigned SW = NUM_LEGS + 1;

  logic [SW-1:0] sync_q;
  leg_req_t [NUM_LEGS-1:0] req;

  hbg_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({en_i, in2_i, in1_i}),
    .sync_o  (sync_q)
  );

  hbg_decode u_dec (
    .en_s    (sync_q[SW-1]),
    .fault_n (fault_n_i),
    .dir_s   (sync_q[NUM_LEGS-1:0]),
    .req_o   (req)
  );

  generate
    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
      hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req[k]),
        .gate_hi_o (gate_hi_o[k]),
        .gate_lo_o (gate_lo_o[k]),
        .hiz_o     (leg_hiz_o[k])
      );
    end
  endgenerate

  assert_fault_off_R3: assert property (@(posedge clk) disable iff (rst)
    !fault_n_i |=> (gate_hi_o == 2'b00 && gate_lo_o == 2'b00 && leg_hiz_o == 2'b11));

  assert_hiz_flag_R10: assert property (@(posedge clk) disable iff (rst)
    leg_hiz_o == ~(gate_hi_o | gate_lo_o));
endmodule

// File: tb/tb_hbridge_gate_ctrl.sv
module tb_hbridge_gate_ctrl;
  localparam int D      = 12;
  localparam int SETTLE = D + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, in1 = 1'b0, in2 = 1'b0, fault_n = 1'b1;
  logic [1:0] ghi, glo, hiz;

  always #10 clk = ~clk;

  hbridge_gate_ctrl #(.DEAD_CYC(D)) dut (
    .clk(clk), .rst(rst), .en_i(en), .in1_i(in1), .in2_i(in2),
    .fault_n_i(fault_n), .gate_hi_o(ghi), .gate_lo_o(glo), .leg_hiz_o(hiz)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [5:0] exp; } sb_item_t;
  sb_item_t sb_q [$];

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act hi/lo/hiz=%b expected %b", tag, act, exp);
    end
  endtask

  // Driver helpers
  task automatic drive(input logic e, input logic a, input logic b, input logic f);
    @(negedge clk);
    en = e; in1 = a; in2 = b; fault_n = f;
  endtask

  task automatic expect_settled(input string tag, input logic [5:0] exp);
    sb_item_t it;
    repeat (SETTLE) @(posedge clk);
    it.tag = tag; it.exp = exp;
    sb_q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Scoreboard monitor
  initial begin
    sb_item_t it;
    forever begin
      wait (sb_q.size() != 0);
      @(negedge clk);
      it = sb_q.pop_front();
      chk(it.tag, {ghi, glo, hiz}, it.exp);
    end
  end

  // Independent gap / overlap monitor
  initial begin
    int run [2];
    run[0] = 0; run[1] = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        for (int k = 0; k < 2; k++) begin
          if (ghi[k] && glo[k]) chk("R5 overlap", {ghi, glo, hiz}, 6'b0);
          if (!ghi[k] && !glo[k]) run[k]++;
          else begin
            if (run[k] != 0 && run[k] < D) begin
              n_cmp++; n_bad++;
              $display("FAIL R6 leg%0d dead gap act=%0d expected>=%0d", k, run[k], D);
            end else if (run[k] != 0) n_cmp++;
            run[k] = 0;
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): act=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset state", {ghi, glo, hiz}, {2'b00, 2'b00, 2'b11});

    // R2: disabled, inputs toggling have no effect
    drive(1'b0, 1'b1, 1'b1, 1'b1);
    expect_settled("R2 disabled in=11", {2'b00, 2'b00, 2'b11});
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    expect_settled("R2 disabled in=10", {2'b00, 2'b00, 2'b11});
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    repeat (4) @(posedge clk);

    // R7: enable rise with in=00; low sides on at edge D+3
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    repeat (D + 2) @(posedge clk);
    #1 chk("R7 still waiting", {ghi, glo, hiz}, {2'b00, 2'b00, 2'b11});
    @(posedge clk);
    #1 chk("R7 low sides on", {ghi, glo, hiz}, {2'b00, 2'b11, 2'b00});

    // R9 / R6 / R8: leg 0 switches low->high, leg 1 holds low
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    #1 chk("R9 no change before third edge", {ghi, glo, hiz}, {2'b00, 2'b11, 2'b00});
    @(posedge clk);
    #1 chk("R9 old gate off at third edge", {ghi, glo, hiz}, {2'b00, 2'b10, 2'b01});
    repeat (D - 1) @(posedge clk);
    #1 chk("R6 still in dead time, R8 leg1 held", {ghi, glo, hiz}, {2'b00, 2'b10, 2'b01});
    @(posedge clk);
    #1 chk("R6 high side after exact dead time", {ghi, glo, hiz}, {2'b01, 2'b10, 2'b00});

    // R4 truth table via scoreboard
    drive(1'b1, 1'b0, 1'b1, 1'b1);
    expect_settled("R4 in=01", {2'b10, 2'b01, 2'b00});
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    expect_settled("R4 in=11", {2'b11, 2'b00, 2'b00});
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    expect_settled("R4 in=10", {2'b01, 2'b10, 2'b00});
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    expect_settled("R4 in=00", {2'b00, 2'b11, 2'b00});

    // R3: fault acts on the next edge
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    expect_settled("R4 in=11 before fault", {2'b11, 2'b00, 2'b00});
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    @(posedge clk);
    #1 chk("R3 fault off next edge", {ghi, glo, hiz}, {2'b00, 2'b00, 2'b11});
    // R7: fault clearing waits full dead time (fault path is not synchronized)
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    repeat (D) @(posedge clk);
    #1 chk("R7 fault recovery waiting", {ghi, glo, hiz}, {2'b00, 2'b00, 2'b11});
    @(posedge clk);
    #1 chk("R7 fault recovery on", {ghi, glo, hiz}, {2'b11, 2'b00, 2'b00});

    // R2 / R10: enable low while running
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    expect_settled("R2 enable dropped", {2'b00, 2'b00, 2'b11});

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule